// File: doc/BRIEF.md
# Pixel Input Conditioning Stage

This block sits between a video timing source and a display serial host. Each pixel clock it takes one 30-bit pixel, built from three 10-bit components, together with data-enable, horizontal sync and vertical sync. It hands the same stream on with every sync made active-high. The three components are rearranged into the luma/red, blue-chroma/green and red-chroma/blue slots the host expects. When a 4:2:2 chroma output is selected, both pixels of each even/odd pair are given one shared pair of chroma values.

All configuration comes from static fields that are held steady while a frame is in flight. Three per-signal invert bits normalise polarity. Three 2-bit slot selectors route the components. A chroma enable and a 2-bit decimation mode choose which chroma the pair shares: the first pixel's, the second pixel's, or the floor average of the two. Every output appears exactly two pixel clocks after its input, syncs included, so the stream stays aligned.

Top module: `pic_cond`

## Requirements
- R1: `out_de`, `out_hs` and `out_vs` equal the matching input XOR its invert bit (`cfg_de_inv`, `cfg_hs_inv`, `cfg_vs_inv`), two clock cycles after the input is presented.
- R2: Component k of `in_pix` occupies bits [10k+9:10k]. Output slot 0 (bits [9:0]), slot 1 (bits [19:10]) and slot 2 (bits [29:20]) carry the input component named by `cfg_sel_y`, `cfg_sel_cb` and `cfg_sel_cr` respectively, two cycles later.
- R3: A selector value of 3 routes input component 0.
- R4: With `cfg_chroma_en` = 0, slots 1 and 2 carry the routed components unchanged.
- R5: With `cfg_chroma_en` = 1 and `cfg_chroma_mode` = 0, both pixels of a pair output the first (even) pixel's routed slot 1 and slot 2 values.
- R6: With mode 1, both pixels of a pair output the second (odd) pixel's routed slot 1 and slot 2 values.
- R7: With mode 2, both pixels of a pair output, per chroma slot, (even + odd) >> 1, rounding down.
- R8: Pairing restarts at each rising edge of the normalised DE. The first active pixel of a line is even. A last pixel without a partner keeps its own chroma. Pixels with normalised DE low pass routed without sharing.
- R9: Slot 0 is never modified by chroma sharing.
- R10: Mode value 3 behaves as mode 0.
- R11: While `rst_n` is low, `out_de`, `out_hs`, `out_vs` and `out_pix` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_de_inv | input | 1 | Invert the incoming data-enable |
| cfg_hs_inv | input | 1 | Invert the incoming horizontal sync |
| cfg_vs_inv | input | 1 | Invert the incoming vertical sync |
| cfg_sel_y | input | 2 | Source component for slot 0 |
| cfg_sel_cb | input | 2 | Source component for slot 1 |
| cfg_sel_cr | input | 2 | Source component for slot 2 |
| cfg_chroma_en | input | 1 | Enable 4:2:2 chroma sharing |
| cfg_chroma_mode | input | 2 | 0 even, 1 odd, 2 average, 3 as 0 |
| in_de | input | 1 | Raw data-enable |
| in_hs | input | 1 | Raw horizontal sync |
| in_vs | input | 1 | Raw vertical sync |
| in_pix | input | 30 | Three 10-bit components |
| out_de | output | 1 | Active-high data-enable |
| out_hs | output | 1 | Active-high horizontal sync |
| out_vs | output | 1 | Active-high vertical sync |
| out_pix | output | 30 | Routed and chroma-conditioned pixel |

## Verification
The bench sweeps all 64 combinations of the three slot selectors. Each one is paired with a rotating choice of invert bits, chroma mode and chroma enable, and driven with pixel values that differ per component and per pixel. Lines of length one, two, three, four and five are separated by blanking. This tells apart pairing that restarts at DE rise from pairing that runs on across lines, separates the lone odd-length tail from a full pair, and distinguishes even, odd and average selection. The average is also checked on odd sums, where the floor matters. Blanking cycles with the invert bits set show whether the polarity is applied and whether sharing wrongly reaches inactive pixels.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        CH_EVEN = 2'd0,
        CH_ODD  = 2'd1,
        CH_AVG  = 2'd2,
        CH_RSVD = 2'd3
    } chroma_mode_e;
endpackage

// File: rtl/pic_polarity.sv
module pic_polarity #(
    parameter int NSIG = 3
) (
    input  logic [NSIG-1:0] raw_i,
    input  logic [NSIG-1:0] inv_i,
    output logic [NSIG-1:0] norm_o
);
    for (genvar i = 0; i < NSIG; i++) begin : g_sig
        assign norm_o[i] = raw_i[i] ^ inv_i[i];
    end
endmodule

// File: rtl/pic_xbar.sv
module pic_xbar #(
    parameter int COMP_W = 10,
    parameter int NCOMP  = 3,
    parameter int SEL_W  = 2
) (
    input  logic [NCOMP*COMP_W-1:0] pix_i,
    input  logic [NCOMP*SEL_W-1:0]  sel_i,
    output logic [NCOMP*COMP_W-1:0] pix_o
);
    for (genvar s = 0; s < NCOMP; s++) begin : g_slot
        logic [SEL_W-1:0] sel;
        int unsigned      idx;
        assign sel = sel_i[s*SEL_W +: SEL_W];
        always_comb begin
            idx = 32'(sel);
            if (idx >= NCOMP) begin
                idx = 0;   // out-of-range selectors fall back to component 0
            end
            pix_o[s*COMP_W +: COMP_W] = pix_i[idx*COMP_W +: COMP_W];
        end
    end
endmodule

// File: rtl/pic_chroma_share.sv
module pic_chroma_share
    import pic_pkg::*;
#(
    parameter int COMP_W = 10,
    parameter int NCHR   = 2
) (
    input  chroma_mode_e             mode_i,
    input  logic [NCHR*COMP_W-1:0]   even_i,
    input  logic [NCHR*COMP_W-1:0]   odd_i,
    output logic [NCHR*COMP_W-1:0]   pair_o
);
    for (genvar c = 0; c < NCHR; c++) begin : g_chr
        logic [COMP_W-1:0] e_v, o_v;
        logic [COMP_W:0]   sum_v;
        assign e_v   = even_i[c*COMP_W +: COMP_W];
        assign o_v   = odd_i[c*COMP_W +: COMP_W];
        assign sum_v = {1'b0, e_v} + {1'b0, o_v};
        always_comb begin
            unique case (mode_i)
                CH_ODD:  pair_o[c*COMP_W +: COMP_W] = o_v;
                CH_AVG:  pair_o[c*COMP_W +: COMP_W] = sum_v[COMP_W:1];
                default: pair_o[c*COMP_W +: COMP_W] = e_v;
            endcase
        end
    end
endmodule

// File: rtl/pic_cond.sv
module pic_cond
    import pic_pkg::*;
#(
    parameter int COMP_W = 10,
    parameter int SEL_W  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_de_inv,
    input  logic                  cfg_hs_inv,
    input  logic                  cfg_vs_inv,
    input  logic [SEL_W-1:0]      cfg_sel_y,
    input  logic [SEL_W-1:0]      cfg_sel_cb,
    input  logic [SEL_W-1:0]      cfg_sel_cr,
    input  logic                  cfg_chroma_en,
    input  logic [1:0]            cfg_chroma_mode,
    input  logic                  in_de,
    input  logic                  in_hs,
    input  logic                  in_vs,
    input  logic [3*COMP_W-1:0]   in_pix,
    output logic                  out_de,
    output logic                  out_hs,
    output logic                  out_vs,
    output logic [3*COMP_W-1:0]   out_pix
);
    localparam int NCOMP = 3;
    localparam int NCHR  = NCOMP - 1;
    localparam int PIX_W = NCOMP * COMP_W;
    localparam int CHR_W = NCHR * COMP_W;

    typedef struct packed {
        logic             a_de;
        logic             a_hs;
        logic             a_vs;
        logic [PIX_W-1:0] a_pix;
        logic             a_odd;
        logic             b_de;
        logic             b_hs;
        logic             b_vs;
        logic [PIX_W-1:0] b_pix;
        logic             b_odd;
        logic [CHR_W-1:0] pair_c;
        logic [1:0]       warm;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [2:0]       sync_norm;
    logic [PIX_W-1:0] xpix;
    logic [CHR_W-1:0] pair_val;

    pic_polarity #(.NSIG(3)) u_pol (
        .raw_i  ({in_vs, in_hs, in_de}),
        .inv_i  ({cfg_vs_inv, cfg_hs_inv, cfg_de_inv}),
        .norm_o (sync_norm)
    );

    pic_xbar #(.COMP_W(COMP_W), .NCOMP(NCOMP), .SEL_W(SEL_W)) u_xbar (
        .pix_i (in_pix),
        .sel_i ({cfg_sel_cr, cfg_sel_cb, cfg_sel_y}),
        .pix_o (xpix)
    );

    // even pixel sits in stage A, its odd partner is the current input
    pic_chroma_share #(.COMP_W(COMP_W), .NCHR(NCHR)) u_share (
        .mode_i (chroma_mode_e'(cfg_chroma_mode)),
        .even_i (st_q.a_pix[PIX_W-1:COMP_W]),
        .odd_i  (xpix[PIX_W-1:COMP_W]),
        .pair_o (pair_val)
    );

    always_comb begin
        logic [CHR_W-1:0] chr;
        st_d = st_q;
        // stage A: normalised syncs, routed pixel, pair parity
        st_d.a_de  = sync_norm[0];
        st_d.a_hs  = sync_norm[1];
        st_d.a_vs  = sync_norm[2];
        st_d.a_pix = xpix;
        st_d.a_odd = sync_norm[0] & st_q.a_de & ~st_q.a_odd;
        // stage B: chroma sharing
        chr = st_q.a_pix[PIX_W-1:COMP_W];
        if (cfg_chroma_en && st_q.a_de) begin
            if (!st_q.a_odd) begin
                if (sync_norm[0]) begin
                    chr = pair_val;
                end
                st_d.pair_c = chr;
            end else begin
                chr = st_q.pair_c;
            end
        end
        st_d.b_de  = st_q.a_de;
        st_d.b_hs  = st_q.a_hs;
        st_d.b_vs  = st_q.a_vs;
        st_d.b_pix = {chr, st_q.a_pix[COMP_W-1:0]};
        st_d.b_odd = st_q.a_odd;
        if (st_q.warm != 2'd2) begin
            st_d.warm = st_q.warm + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_de  = st_q.b_de;
    assign out_hs  = st_q.b_hs;
    assign out_vs  = st_q.b_vs;
    assign out_pix = st_q.b_pix;

    // R1
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == 2'd2) |->
            (out_de == $past(in_de ^ cfg_de_inv, 2)) &&
            (out_hs == $past(in_hs ^ cfg_hs_inv, 2)) &&
            (out_vs == $past(in_vs ^ cfg_vs_inv, 2)));

    // R9
    luma_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == 2'd2) |-> out_pix[COMP_W-1:0] == $past(st_q.a_pix[COMP_W-1:0]));

    // R5
    pair_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == 2'd2 && out_de && st_q.b_odd &&
         $past(cfg_chroma_en) && $past(cfg_chroma_en, 2)) |->
            out_pix[PIX_W-1:COMP_W] == $past(out_pix[PIX_W-1:COMP_W]));

    // R8
    odd_after_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm != 2'd0 && st_q.b_odd) |-> (out_de && $past(out_de) && !$past(st_q.b_odd)));
endmodule

// File: tb/tb_pic_cond.sv
module tb_pic_cond;
    localparam int W = 10;
    localparam int N = 29;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic de_inv = 0, hs_inv = 0, vs_inv = 0;
    logic [1:0] sel_y = 0, sel_cb = 1, sel_cr = 2;
    logic chroma_en = 0;
    logic [1:0] chroma_mode = 0;
    logic in_de = 0, in_hs = 0, in_vs = 0;
    logic [3*W-1:0] in_pix = '0;
    logic out_de, out_hs, out_vs;
    logic [3*W-1:0] out_pix;

    int checks = 0;
    int fails = 0;

    logic [3*W-1:0] ipix [0:63];
    logic ide [0:63], ihs [0:63], ivs [0:63];
    logic [3*W-1:0] opix [0:63];
    logic ode [0:63], ohs [0:63], ovs [0:63];
    int pos [0:63];

    always #5 clk = ~clk;

    pic_cond dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_de_inv(de_inv), .cfg_hs_inv(hs_inv), .cfg_vs_inv(vs_inv),
        .cfg_sel_y(sel_y), .cfg_sel_cb(sel_cb), .cfg_sel_cr(sel_cr),
        .cfg_chroma_en(chroma_en), .cfg_chroma_mode(chroma_mode),
        .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs), .in_pix(in_pix),
        .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs), .out_pix(out_pix)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] route(input logic [3*W-1:0] p, input logic [1:0] s);
        int c;
        c = (s == 2'd3) ? 0 : int'(s);
        return p[c*W +: W];
    endfunction

    function automatic logic [W-1:0] gen_comp(input int k, input int c, input int sc);
        int v;
        v = (k * 37 + c * 211 + sc * 59) ^ (k * k * 5 + sc);
        return v[W-1:0];
    endfunction

    // line layout: gap 2 then a line, lengths 1,2,3,5,4, then trailing gap
    function automatic bit de_at(input int j);
        int lens [5] = '{1, 2, 3, 5, 4};
        int p = 0;
        foreach (lens[i]) begin
            p += 2;
            if (j >= p && j < p + lens[i]) return 1'b1;
            p += lens[i];
        end
        return 1'b0;
    endfunction

    function automatic logic [W-1:0] share(input logic [1:0] m, input logic [W-1:0] e,
                                           input logic [W-1:0] o);
        logic [W:0] s;
        s = {1'b0, e} + {1'b0, o};
        case (m)
            2'd1:    return o;
            2'd2:    return s[W:1];
            default: return e;
        endcase
    endfunction

    task automatic run_scenario(input int sc);
        sel_y       = 2'(sc % 4);
        sel_cb      = 2'((sc / 4) % 4);
        sel_cr      = 2'((sc / 16) % 4);
        chroma_mode = 2'((sc + sc / 4) % 4);
        chroma_en   = (sc % 5) != 0;
        {vs_inv, hs_inv, de_inv} = 3'((sc / 3) % 8);
        // flush with idle cycles under the new configuration
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            in_de = de_inv; in_hs = hs_inv; in_vs = vs_inv;
        end
        for (int j = 0; j < N + 2; j++) begin
            @(negedge clk);
            opix[j] = out_pix; ode[j] = out_de; ohs[j] = out_hs; ovs[j] = out_vs;
            ide[j] = (j < N) ? de_at(j) : 1'b0;
            ihs[j] = (j % 7) == 0;
            ivs[j] = (j % 11) == 3;
            for (int c = 0; c < 3; c++) ipix[j][c*W +: W] = gen_comp(j, c, sc);
            in_de = ide[j] ^ de_inv;
            in_hs = ihs[j] ^ hs_inv;
            in_vs = ivs[j] ^ vs_inv;
            in_pix = ipix[j];
        end
        for (int k = 0; k < N; k++) begin
            pos[k] = (ide[k] && k > 0 && ide[k-1]) ? pos[k-1] + 1 : 0;
        end
        for (int k = 0; k < N; k++) begin
            logic [W-1:0] ey, ec [2];
            logic [1:0] sl [2];
            string tag;
            sl[0] = sel_cb; sl[1] = sel_cr;
            // R1 syncs
            check({ode[k+2], ohs[k+2], ovs[k+2]} == {ide[k], ihs[k], ivs[k]}, "R1", "syncs",
                  {29'd0, ode[k+2], ohs[k+2], ovs[k+2]}, {29'd0, ide[k], ihs[k], ivs[k]});
            // R2 / R3 / R9 luma slot
            ey = route(ipix[k], sel_y);
            tag = (sel_y == 2'd3) ? "R3" : (chroma_en ? "R9" : "R2");
            check(opix[k+2][W-1:0] == ey, tag, "slot0", 32'(opix[k+2][W-1:0]), 32'(ey));
            for (int s = 0; s < 2; s++) begin
                ec[s] = route(ipix[k], sl[s]);
                if (!chroma_en) tag = (sl[s] == 2'd3) ? "R3" : "R4";
                else if (!ide[k]) tag = "R8";
                else if (pos[k] % 2 == 0) begin
                    if (ide[k+1]) begin
                        ec[s] = share(chroma_mode, route(ipix[k], sl[s]), route(ipix[k+1], sl[s]));
                        tag = chroma_mode == 2'd0 ? "R5" : chroma_mode == 2'd1 ? "R6" :
                              chroma_mode == 2'd2 ? "R7" : "R10";
                    end else tag = "R8";
                end else begin
                    ec[s] = share(chroma_mode, route(ipix[k-1], sl[s]), route(ipix[k], sl[s]));
                    tag = chroma_mode == 2'd0 ? "R5" : chroma_mode == 2'd1 ? "R6" :
                          chroma_mode == 2'd2 ? "R7" : "R10";
                end
                check(opix[k+2][(s+1)*W +: W] == ec[s], tag, "chroma slot",
                      32'(opix[k+2][(s+1)*W +: W]), 32'(ec[s]));
            end
        end
    endtask

    initial begin
        in_de = 1'b1; in_hs = 1'b1; in_vs = 1'b1; in_pix = '1;
        repeat (3) @(negedge clk);
        // R11 reset state
        check({out_de, out_hs, out_vs} == 3'b000, "R11", "syncs in reset",
              {29'd0, out_de, out_hs, out_vs}, 32'd0);
        check(out_pix == '0, "R11", "pixel in reset", 32'(out_pix), 32'd0);
        rst_n = 1'b1;
        for (int sc = 0; sc < 64; sc++) run_scenario(sc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog all-R actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule